// File: doc/BRIEF.md
# Periodic Rate Selector with Square-Wave and Flag Outputs

This block turns a 32.768 kHz timebase enable into a selectable periodic event. A 15-stage binary prescaler advances once for each timebase pulse. A 4-bit rate code chooses one of its stages as the active tap, or chooses no tap at all. That tap drives two consumers at one shared rate. The first is a square-wave pin. The second is a sticky periodic flag, which can be passed on as an interrupt request.

Each consumer has its own enable. The square-wave pin is controlled by a square-wave enable or by a full-rate override, which puts the timebase itself on the pin. The interrupt request is the flag gated by an interrupt enable. Software clears the flag through a one-cycle clear strobe, which stands in for a read of the status register.

Top module: `prs_rate_select`

## Requirements
- R1: While `rst` is high at a clock edge, the prescaler count, `sqw`, `pflag` and `irq` all become 0.
- R2: The prescaler count advances by one on every clock edge where `tick` is 1. For a rate code c from 3 to 15, the tap is count bit c-2. This gives a period of 2^(c-1) ticks, from 8192 Hz at code 3 down to 2 Hz at code 15.
- R3: Rate code 1 selects count bit 6 (256 Hz) and rate code 2 selects count bit 7 (128 Hz). These are the same taps as codes 8 and 9.
- R4: With rate code 0 the tap is held at 0. No flag is set, and `sqw` stays low unless `e32k` is 1.
- R5: A 0-to-1 transition of the tap sets `pflag` at the next clock edge, which is one cycle after the tick edge that moved the count. `pflag` then stays at 1 until it is cleared.
- R6: A `flag_clr` pulse clears `pflag` at the next edge. If a tap rise happens in the same cycle as the clear, the set wins and `pflag` stays at 1.
- R7: `irq` is registered together with `pflag` and equals the flag ANDed with `pie` from the previous cycle. With `pie` at 0, `irq` stays low even while `pflag` is 1.
- R8: With `e32k` = 0 and `sqwe` = 1, `sqw` follows the tap with one cycle of register delay.
- R9: With `e32k` = 1, `sqw` equals `tick` delayed by one cycle, whatever the values of `rate_code` and `sqwe`.
- R10: With `e32k` = 0 and `sqwe` = 0, `sqw` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase enable at 32.768 kHz |
| rate_code | input | CODE_W | Rate select code; 0 disables the tap |
| pie | input | 1 | Periodic interrupt enable |
| sqwe | input | 1 | Square-wave output enable |
| e32k | input | 1 | Puts the raw timebase on the square-wave pin |
| flag_clr | input | 1 | One-cycle clear strobe for the periodic flag |
| sqw | output | 1 | Square-wave output pin |
| pflag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest case to reach from the ports is a tap rise that lands in exactly the same cycle as a clear strobe. The bench keeps its own count of the ticks it has issued. It steps the count until the next tick will raise the selected bit, issues that tick, and drives `flag_clr` in the following cycle, when the rise is visible to the flag register. The 2 Hz code is reached by issuing ticks back to back until bit 13 is about to rise. The bench then checks that the flag is still clear one tick before that point and set one tick after it.

// File: rtl/prs_pkg.sv
package prs_pkg;
  // taps used by the two low codes that repeat slower rates
  localparam int ALIAS_LO_IDX = 6;
  localparam int ALIAS_HI_IDX = 7;

  // prescaler stage selected by a rate code, clamped to the stages present
  function automatic int tap_index(input int code, input int stages);
    int idx;
    if (code == 1)      idx = ALIAS_LO_IDX;
    else if (code == 2) idx = ALIAS_HI_IDX;
    else                idx = code - 2;
    if (idx < 0)           idx = 0;
    if (idx > stages - 1)  idx = stages - 1;
    return idx;
  endfunction
endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler #(
  parameter int STAGES = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] rate_code,
  output logic              tap
);
  localparam int IDX_W = $clog2(STAGES);

  logic [STAGES-1:0] cnt;
  logic [IDX_W-1:0]  sel_idx;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_comb begin
    sel_idx = IDX_W'(prs_pkg::tap_index(int'(rate_code), STAGES));
    tap     = (rate_code != '0) && cnt[sel_idx];
  end
endmodule

// File: rtl/prs_flag.sv
module prs_flag (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic flag_clr,
  input  logic pie,
  output logic pflag,
  output logic irq
);
  logic tap_q;
  logic rise;
  logic flag_d;

  always_comb begin
    rise   = tap && !tap_q;
    // a new event outranks a clear in the same cycle
    flag_d = rise || (pflag && !flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= 1'b0;
      pflag <= 1'b0;
      irq   <= 1'b0;
    end else begin
      tap_q <= tap;
      pflag <= flag_d;
      irq   <= flag_d && pie;
    end
  end
endmodule

// File: rtl/prs_sqw_gate.sv
module prs_sqw_gate (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic tick,
  input  logic sqwe,
  input  logic e32k,
  output logic sqw
);
  always_ff @(posedge clk) begin
    if (rst)       sqw <= 1'b0;
    else if (e32k) sqw <= tick;
    else if (sqwe) sqw <= tap;
    else           sqw <= 1'b0;
  end
endmodule

// File: rtl/prs_rate_select.sv
module prs_rate_select #(
  parameter int STAGES = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie,
  input  logic              sqwe,
  input  logic              e32k,
  input  logic              flag_clr,
  output logic              sqw,
  output logic              pflag,
  output logic              irq
);
  logic tap;

  prs_prescaler #(.STAGES(STAGES), .CODE_W(CODE_W)) i_prescaler (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code), .tap(tap)
  );

  prs_flag i_flag (
    .clk(clk), .rst(rst), .tap(tap), .flag_clr(flag_clr), .pie(pie),
    .pflag(pflag), .irq(irq)
  );

  prs_sqw_gate i_sqw (
    .clk(clk), .rst(rst), .tap(tap), .tick(tick), .sqwe(sqwe), .e32k(e32k),
    .sqw(sqw)
  );
endmodule

// File: rtl/prs_rate_select_chk.sv
module prs_rate_select_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CODE_W-1:0] rate_code,
  input logic              pie,
  input logic              sqwe,
  input logic              e32k,
  input logic              flag_clr,
  input logic              sqw,
  input logic              pflag,
  input logic              irq
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7: a request never appears without the flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    irq |-> pflag);

  // R7: request equals flag gated by the enable seen one cycle earlier
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    irq == (pflag && $past(pie)));

  // R4: a disabled tap cannot raise the flag
  p_code0_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rate_code) == '0 && !$past(pflag)) |-> !pflag);

  // R6: a clear with no possible event empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(flag_clr) && $past(rate_code) == '0) |-> !pflag);

  // R5: the flag is sticky until a clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(pflag) && !$past(flag_clr)) |-> pflag);

  // R9: override copies the timebase
  p_e32k_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(e32k) |-> (sqw == $past(tick)));

  // R10: both enables off keeps the pin low
  p_off_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(!e32k && !sqwe)) |-> !sqw);
endmodule

bind prs_rate_select prs_rate_select_chk #(.CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code), .pie(pie),
  .sqwe(sqwe), .e32k(e32k), .flag_clr(flag_clr), .sqw(sqw), .pflag(pflag),
  .irq(irq)
);

// File: tb/test_prs_rate_select.sv
module test_prs_rate_select;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       e32k = 1'b0;
  logic       flag_clr = 1'b0;
  logic       sqw, pflag, irq;

  int total = 0;
  int bad = 0;
  logic [14:0] mcount = '0;

  always #2.5 clk = ~clk;

  prs_rate_select i_prs_rate_select (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code), .pie(pie),
    .sqwe(sqwe), .e32k(e32k), .flag_clr(flag_clr), .sqw(sqw), .pflag(pflag),
    .irq(irq)
  );

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int exp_idx(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction

  function automatic logic will_rise(input logic [14:0] c, input int idx);
    logic [14:0] n;
    n = c + 15'd1;
    return !c[idx] && n[idx];
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    mcount = mcount + 15'd1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fast_tick();
    @(negedge clk) tick = 1'b1;
    mcount = mcount + 15'd1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] code, input logic s, input logic e, input logic p);
    @(negedge clk);
    rate_code = code; sqwe = s; e32k = e; pie = p;
    @(negedge clk);
    pulse_clr();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sqw, 1'b0, "R1", "sqw after reset");
    check(pflag, 1'b0, "R1", "pflag after reset");
    check(irq, 1'b0, "R1", "irq after reset");
  endtask

  task automatic t_tap_follow(input logic [3:0] code, input int n, input string req);
    set_mode(code, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      do_tick();
      check(sqw, mcount[exp_idx(int'(code))], req, "sqw follows tap");
    end
  endtask

  task automatic t_flag_exact_r5();
    set_mode(4'd4, 1'b0, 1'b0, 1'b0);
    while (!will_rise(mcount, 2)) do_tick();
    check(pflag, 1'b0, "R5", "flag before rise");
    do_tick();
    check(pflag, 1'b1, "R5", "flag at rise");
    for (int i = 0; i < 6; i++) do_tick();
    check(pflag, 1'b1, "R5", "flag sticky");
    pulse_clr();
    check(pflag, 1'b0, "R6", "flag cleared");
  endtask

  task automatic t_set_wins_r6();
    set_mode(4'd3, 1'b0, 1'b0, 1'b0);
    while (!will_rise(mcount, 1)) do_tick();
    pulse_clr();
    check(pflag, 1'b0, "R6", "flag clear before race");
    @(negedge clk) tick = 1'b1;
    mcount = mcount + 15'd1;
    @(negedge clk) begin tick = 1'b0; flag_clr = 1'b1; end
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
    check(pflag, 1'b1, "R6", "set wins over clear");
    pulse_clr();
    check(pflag, 1'b0, "R6", "later clear");
  endtask

  task automatic t_irq_r7();
    set_mode(4'd3, 1'b0, 1'b0, 1'b0);
    while (!will_rise(mcount, 1)) do_tick();
    do_tick();
    check(pflag, 1'b1, "R7", "flag set for gating");
    check(irq, 1'b0, "R7", "irq masked");
    @(negedge clk) pie = 1'b1;
    @(negedge clk);
    check(irq, 1'b1, "R7", "irq enabled");
    pulse_clr();
    check(irq, 1'b0, "R7", "irq after clear");
    pie = 1'b0;
  endtask

  task automatic t_code0_r4();
    set_mode(4'd0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      do_tick();
      check(sqw, 1'b0, "R4", "sqw with code 0");
      check(pflag, 1'b0, "R4", "flag with code 0");
    end
  endtask

  task automatic t_e32k_r9();
    set_mode(4'd0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) tick = 1'b1;
      mcount = mcount + 15'd1;
      @(negedge clk) tick = 1'b0;
      check(sqw, 1'b1, "R9", "sqw high after tick");
      @(negedge clk);
      check(sqw, 1'b0, "R9", "sqw low after idle");
    end
  endtask

  task automatic t_off_r10();
    set_mode(4'd3, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      do_tick();
      check(sqw, 1'b0, "R10", "sqw disabled");
    end
  endtask

  task automatic t_slowest_r2();
    set_mode(4'd15, 1'b0, 1'b0, 1'b0);
    while (!will_rise(mcount, 13)) fast_tick();
    @(negedge clk);
    @(negedge clk);
    check(pflag, 1'b0, "R2", "2 Hz flag before bit 13 rises");
    do_tick();
    check(pflag, 1'b1, "R2", "2 Hz flag at bit 13 rise");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tap_follow(4'd3, 12, "R8");
    t_tap_follow(4'd9, 300, "R2");
    t_tap_follow(4'd1, 300, "R3");
    t_tap_follow(4'd2, 300, "R3");
    t_flag_exact_r5();
    t_set_wins_r6();
    t_irq_r7();
    t_code0_r4();
    t_e32k_r9();
    t_off_r10();
    t_slowest_r2();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule